// File: doc/BRIEF.md
# Radix-8 Signed-Digit Booth Partial-Product Stage

This block forms one partial product of an unsigned radix-8 Booth multiplier. It takes an unsigned multiplicand and one overlapping 4-bit slice of the multiplier. It returns the product of the multiplicand and that slice's Booth digit. The result is a redundant binary signed-digit vector with two bit-vectors, a plus vector and a minus vector. The value of digit position i is plus[i] minus minus[i], so each position holds -1, 0 or +1. No carry-propagate adder is needed.

The awkward triple multiple is formed by wiring alone: four times the multiplicand goes on the plus vector and the multiplicand itself on the minus vector. Every negative multiple is the matching positive one with the two vectors exchanged, so no sign extension is needed. The result is not shifted. The surrounding multiplier places it at weight 8^i and reduces all partial products in a signed-digit adder tree.

The slice for group i is {b(3i+2), b(3i+1), b(3i), b(3i-1)}. For the lowest group, the bit below the slice is zero. The multiplier is zero-extended so that the top group is nonnegative, which gives ceil((n+1)/3) groups for an n-bit multiplier.

Each pair of multiplicand and slice enters on a valid/ready stream and leaves from one register on a second valid/ready stream:
- `up_ready` is high when the output register is empty or is being drained in the same cycle.
- An input is taken on any rising edge where `up_valid` and `up_ready` are both high.
- Once `dn_valid` rises, the result stays on the output unchanged until a rising edge with `dn_ready` high.

Top module: `booth3_sd_ppgen`

## Requirements
- R1: For every accepted pair, the value plus minus minus, read as unsigned numbers, equals the Booth digit times the multiplicand. The digit is -4*s[3] + 2*s[2] + s[1] + s[0] for slice s.
- R2: Slices 0000 and 1111 give plus = 0 and minus = 0.
- R3: Slices 0001 and 0010 give plus = M. Slices 0011 and 0100 give plus = 2M. Slice 0111 gives plus = 4M. In all five cases minus = 0.
- R4: Slices 1101 and 1110 give minus = M. Slices 1011 and 1100 give minus = 2M. Slice 1000 gives minus = 4M. In all five cases plus = 0.
- R5: Slices 0101 and 0110 give plus = 4M and minus = M. For M = 74 this reads plus = 296 and minus = 74.
- R6: Slices 1001 and 1010 give the R5 result with the vectors exchanged: plus = M and minus = 4M.
- R7: Each output vector is MCAND_W+3 bits wide. With an all-ones multiplicand, 4M appears in full and is not truncated.
- R8: `up_ready` equals NOT `dn_valid` OR `dn_ready`. An accepted input appears on the outputs with `dn_valid` high after the next rising edge. While `dn_valid` is high and `dn_ready` is low, the outputs do not change.
- R9: After reset, `dn_valid` is 0, `up_ready` is 1, and both vectors are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Input pair present |
| up_ready | output | 1 | Stage can take an input pair |
| up_mcand | input | MCAND_W | Unsigned multiplicand M |
| up_slice | input | 4 | Overlapping multiplier slice, MSB first |
| dn_valid | output | 1 | Partial product present |
| dn_ready | input | 1 | Consumer takes the partial product |
| dn_plus | output | MCAND_W+3 | Plus bits of the signed-digit result |
| dn_minus | output | MCAND_W+3 | Minus bits of the signed-digit result |

## Verification
The assertions take for granted that `up_mcand` and `up_slice` are known and stable whenever `up_valid` is high at a rising edge. They also assume the multiplicand is unsigned, so that plus minus minus compares as a plain integer. The bench changes inputs only on falling edges. It keeps each pair on the bus until it is accepted. It sweeps all sixteen slices over zero, small, all-ones and random multiplicands while `dn_ready` is toggled at random to force stalls.

// File: rtl/booth3_sd_pkg.sv
package booth3_sd_pkg;
  typedef enum logic [2:0] {
    MAG_ZERO  = 3'd0,
    MAG_ONE   = 3'd1,
    MAG_TWO   = 3'd2,
    MAG_THREE = 3'd3,
    MAG_FOUR  = 3'd4
  } mag_e;

  typedef struct packed {
    logic negate;
    mag_e mag;
  } pick_t;
endpackage

// File: rtl/booth3_slice_decode.sv
module booth3_slice_decode
  import booth3_sd_pkg::*;
(
  input  logic [3:0] slice,
  output pick_t      pick
);
  logic [2:0] up_sum;
  logic [2:0] low_mag;

  always_comb begin
    up_sum  = {1'b0, slice[2], 1'b0} + {2'b0, slice[1]} + {2'b0, slice[0]};
    low_mag = 3'd4 - up_sum;
    if (!slice[3]) begin
      pick.negate = 1'b0;
      pick.mag    = mag_e'(up_sum);
    end else if (up_sum == 3'd4) begin
      pick.negate = 1'b0;
      pick.mag    = MAG_ZERO;
    end else begin
      pick.negate = 1'b1;
      pick.mag    = mag_e'(low_mag);
    end
  end
endmodule

// File: rtl/booth3_mult_route.sv
module booth3_mult_route
  import booth3_sd_pkg::*;
#(
  parameter int MCAND_W = 16,
  localparam int PP_W   = MCAND_W + 3
) (
  input  logic [MCAND_W-1:0] mcand,
  input  pick_t              pick,
  output logic [PP_W-1:0]    plus,
  output logic [PP_W-1:0]    minus
);
  logic [PP_W-1:0] m1, m2, m4;
  logic [PP_W-1:0] pos_mag, neg_mag;

  assign m1 = PP_W'(mcand);
  assign m2 = m1 << 1;
  assign m4 = m1 << 2;

  always_comb begin
    pos_mag = '0;
    neg_mag = '0;
    unique case (pick.mag)
      MAG_ONE:   pos_mag = m1;
      MAG_TWO:   pos_mag = m2;
      MAG_THREE: begin
        pos_mag = m4;
        neg_mag = m1;
      end
      MAG_FOUR:  pos_mag = m4;
      default:   pos_mag = '0;
    endcase
  end

  for (genvar b = 0; b < PP_W; b++) begin : g_swap
    assign plus[b]  = pick.negate ? neg_mag[b] : pos_mag[b];
    assign minus[b] = pick.negate ? pos_mag[b] : neg_mag[b];
  end
endmodule

// File: rtl/sd_stream_reg.sv
module sd_stream_reg #(
  parameter int DATA_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_plus,
  input  logic [DATA_W-1:0] in_minus,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_plus,
  output logic [DATA_W-1:0] out_minus
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_plus  <= '0;
      out_minus <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_plus  <= in_plus;
        out_minus <= in_minus;
      end
    end
  end
endmodule

// File: rtl/booth3_sd_ppgen.sv
module booth3_sd_ppgen
  import booth3_sd_pkg::*;
#(
  parameter int MCAND_W = 16,
  localparam int PP_W   = MCAND_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [MCAND_W-1:0] up_mcand,
  input  logic [3:0]         up_slice,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [PP_W-1:0]    dn_plus,
  output logic [PP_W-1:0]    dn_minus
);
  pick_t           pick;
  logic [PP_W-1:0] c_plus, c_minus;

  booth3_slice_decode dec_i (
    .slice (up_slice),
    .pick  (pick)
  );

  booth3_mult_route #(.MCAND_W(MCAND_W)) route_i (
    .mcand (up_mcand),
    .pick  (pick),
    .plus  (c_plus),
    .minus (c_minus)
  );

  sd_stream_reg #(.DATA_W(PP_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (up_valid),
    .in_ready  (up_ready),
    .in_plus   (c_plus),
    .in_minus  (c_minus),
    .out_valid (dn_valid),
    .out_ready (dn_ready),
    .out_plus  (dn_plus),
    .out_minus (dn_minus)
  );
endmodule

// File: rtl/booth3_sd_ppgen_chk.sv
module booth3_sd_ppgen_chk #(
  parameter int MCAND_W = 16,
  localparam int PP_W   = MCAND_W + 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               up_valid,
  input logic               up_ready,
  input logic [MCAND_W-1:0] up_mcand,
  input logic [3:0]         up_slice,
  input logic               dn_valid,
  input logic               dn_ready,
  input logic [PP_W-1:0]    dn_plus,
  input logic [PP_W-1:0]    dn_minus
);
  function automatic int digit_of(input logic [3:0] s);
    return (s[2] ? 2 : 0) + int'(s[1]) + int'(s[0]) - (s[3] ? 4 : 0);
  endfunction

  logic take;
  assign take = up_valid && up_ready;

  // R1: value of the signed-digit result equals digit times M
  p_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (int'(dn_plus) - int'(dn_minus)) ==
             digit_of($past(up_slice)) * int'($past(up_mcand)));

  // R2: zero slices give empty vectors
  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && (up_slice == 4'b0000 || up_slice == 4'b1111)
    |=> dn_plus == '0 && dn_minus == '0);

  // R5: positive triple uses 4M and M
  p_triple_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && (up_slice == 4'b0101 || up_slice == 4'b0110)
    |=> dn_plus == (PP_W'($past(up_mcand)) << 2) && dn_minus == PP_W'($past(up_mcand)));

  // R6: negative triple is the exchanged form
  p_neg_triple_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && (up_slice == 4'b1001 || up_slice == 4'b1010)
    |=> dn_minus == (PP_W'($past(up_mcand)) << 2) && dn_plus == PP_W'($past(up_mcand)));

  // R8: accepted input appears next cycle
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dn_valid);

  // R8: stalled output holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_plus) && $stable(dn_minus));
endmodule

bind booth3_sd_ppgen booth3_sd_ppgen_chk #(.MCAND_W(MCAND_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_valid (up_valid),
  .up_ready (up_ready),
  .up_mcand (up_mcand),
  .up_slice (up_slice),
  .dn_valid (dn_valid),
  .dn_ready (dn_ready),
  .dn_plus  (dn_plus),
  .dn_minus (dn_minus)
);

// File: tb/booth3_sd_ppgen_tb_top.sv
`timescale 1ns/1ps
module booth3_sd_ppgen_tb_top;
  localparam int MW = 16;
  localparam int PW = MW + 3;

  typedef struct {
    logic [PW-1:0] plus;
    logic [PW-1:0] minus;
    int            value;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up_valid = 1'b0;
  logic          up_ready;
  logic [MW-1:0] up_mcand = '0;
  logic [3:0]    up_slice = '0;
  logic          dn_valid;
  logic          dn_ready = 1'b0;
  logic [PW-1:0] dn_plus, dn_minus;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit sending = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  booth3_sd_ppgen #(.MCAND_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready),
    .up_mcand(up_mcand), .up_slice(up_slice),
    .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_plus(dn_plus), .dn_minus(dn_minus)
  );

  task automatic check(input bit ok, input string what, input string act, input string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", what, act, expv);
    end
  endtask

  // Expected result built from R2..R6 and the digit from R1
  function automatic exp_t model(input logic [MW-1:0] m, input logic [3:0] s);
    exp_t e;
    logic [PW-1:0] m1;
    m1 = PW'(m);
    e.plus = '0; e.minus = '0;
    e.value = ((s[2] ? 2 : 0) + int'(s[1]) + int'(s[0]) - (s[3] ? 4 : 0)) * int'(m);
    case (s)
      4'b0001, 4'b0010: begin e.plus = m1;       e.tag = "R3"; end
      4'b0011, 4'b0100: begin e.plus = m1 << 1;  e.tag = "R3"; end
      4'b0111:          begin e.plus = m1 << 2;  e.tag = "R3"; end
      4'b1101, 4'b1110: begin e.minus = m1;      e.tag = "R4"; end
      4'b1011, 4'b1100: begin e.minus = m1 << 1; e.tag = "R4"; end
      4'b1000:          begin e.minus = m1 << 2; e.tag = "R4"; end
      4'b0101, 4'b0110: begin e.plus = m1 << 2; e.minus = m1; e.tag = "R5"; end
      4'b1001, 4'b1010: begin e.minus = m1 << 2; e.plus = m1; e.tag = "R6"; end
      default:          e.tag = "R2";
    endcase
    return e;
  endfunction

  task automatic send(input logic [MW-1:0] m, input logic [3:0] s, input string tag);
    exp_t e;
    e = model(m, s);
    if (tag != "") e.tag = tag;
    @(negedge clk);
    up_valid = 1'b1; up_mcand = m; up_slice = s;
    #1;
    while (!up_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  // Monitor: sets ready at the falling edge, compares what is taken at the next rising edge
  initial begin : monitor
    logic [PW-1:0] held_p, held_m;
    bit was_stalled;
    was_stalled = 1'b0;
    held_p = '0; held_m = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (was_stalled && dn_valid)
          check(dn_plus == held_p && dn_minus == held_m, "R8 hold",
                $sformatf("%0d/%0d", dn_plus, dn_minus), $sformatf("%0d/%0d", held_p, held_m));
        dn_ready = sending ? (($urandom % 4) != 0) : 1'b1;
        #2;
        check(up_ready == (!dn_valid || dn_ready), "R8 ready",
              $sformatf("%0b", up_ready), $sformatf("%0b", !dn_valid || dn_ready));
        was_stalled = dn_valid && !dn_ready;
        held_p = dn_plus; held_m = dn_minus;
        if (dn_valid && dn_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R8 spurious output", "valid", "idle");
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(dn_plus == e.plus && dn_minus == e.minus, e.tag,
                  $sformatf("%0d/%0d", dn_plus, dn_minus), $sformatf("%0d/%0d", e.plus, e.minus));
            check(int'(dn_plus) - int'(dn_minus) == e.value, "R1",
                  $sformatf("%0d", int'(dn_plus) - int'(dn_minus)), $sformatf("%0d", e.value));
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        finish_run();
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R9: reset state
    check(dn_valid == 1'b0 && up_ready == 1'b1 && dn_plus == '0 && dn_minus == '0, "R9",
          $sformatf("%0b %0b %0d %0d", dn_valid, up_ready, dn_plus, dn_minus), "0 1 0 0");
    rst_n = 1'b1;
    sending = 1'b1;
    // R5: worked example with M = 74
    send(16'd74, 4'b0101, "R5");
    check(model(16'd74, 4'b0101).plus == 19'd296, "R5 example", "296", "296");
    // R6: exchanged triple
    send(16'd74, 4'b1010, "R6");
    // R7: all-ones multiplicand, full 4M
    send({MW{1'b1}}, 4'b0111, "R7");
    send({MW{1'b1}}, 4'b1000, "R7");
    send({MW{1'b1}}, 4'b0110, "R7");
    // All slices over several multiplicands
    for (int k = 0; k < 6; k++) begin
      logic [MW-1:0] m;
      case (k)
        0: m = '0;
        1: m = 16'd1;
        2: m = 16'd74;
        3: m = {MW{1'b1}};
        4: m = 16'hA5A5;
        default: m = MW'($urandom);
      endcase
      for (int s = 0; s < 16; s++) send(m, 4'(s), "");
    end
    for (int r = 0; r < 200; r++) send(MW'($urandom), 4'($urandom), "");
    sending = 1'b0;
    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R8 drain", $sformatf("%0d", sb.size()), "0");
    finish_run();
  end
endmodule